// File: doc/BRIEF.md
# NaN-Boxing Floating-Point Register File

This block holds the floating-point architectural registers of a core that runs both single- and double-precision arithmetic. Every register is 64 bits wide. A 32-bit (narrow) result written into the file is stored with its upper half set to ones. A narrow read checks that upper half. If the upper half is not all ones, the read returns a boxed single-precision canonical NaN instead of the stored bits. Wide (64-bit) accesses store and return the full register unchanged.

The block also keeps the two-bit floating-point unit state: 0 off, 1 initial, 2 clean, 3 dirty. It keeps a summary-dirty bit beside that state. Any access raises a combinational illegal-access flag in two cases: when the unit is off, or when the width used is not enabled. A write flagged this way is dropped. A write that commits moves the state to dirty. Control logic outside the block may load a new state through a dedicated port. The arithmetic units and the decoding of control registers sit outside this block.

Top module: `fp_boxed_regfile`

## Requirements
- R1: Synchronous active-low reset clears all 32 registers to zero, sets the state to 0 (off) and clears the summary-dirty bit.
- R2: A committed narrow write stores bits 63:32 as all ones and bits 31:0 from the write data. Bits 63:32 of the write data are discarded.
- R3: A narrow read of a register whose bits 63:32 are all ones returns the full 64-bit value unchanged. This holds exactly when the value is unsigned at or above 0xFFFFFFFF_00000000.
- R4: A narrow read of a register whose upper half is not all ones returns 0xFFFFFFFF_7FC00000.
- R5: A wide write stores all 64 bits, and a wide read returns them without filtering.
- R6: While the state is 0, any enabled read or write drives `illegal` high in the same cycle. Such a write changes neither the registers nor the state.
- R7: A narrow access needs `en_single`, and a wide access needs `en_double`. Otherwise `illegal` goes high and the write is dropped.
- R8: A committed write sets the state to 3 and sets summary-dirty on the next edge. A state load in the same cycle takes priority, and summary-dirty then becomes 1 only if the loaded value is 3.
- R9: When a committed write and a read hit the same register in the same cycle, the read returns the new value as it will be stored, narrow-filtered if the read is narrow.
- R10: Reads never change the state or the summary-dirty bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_single | input | 1 | Single-precision accesses enabled |
| en_double | input | 1 | Double-precision accesses enabled |
| fs_load | input | 1 | Load `fs_load_val` into the unit state |
| fs_load_val | input | 2 | State value to load |
| fs_state | output | 2 | Current unit state (0 off, 1 initial, 2 clean, 3 dirty) |
| fs_summary_dirty | output | 1 | Summary-dirty bit |
| wr_en | input | 1 | Write request |
| wr_addr | input | 5 | Write register index |
| wr_narrow | input | 1 | 1: 32-bit write, 0: 64-bit write |
| wr_data | input | 64 | Write data |
| rd_en | input | 2 | Read request per port (bit 0 port A, bit 1 port B) |
| rd_addr | input | 10 | Read indices, port A in bits 4:0, port B in bits 9:5 |
| rd_narrow | input | 2 | Narrow-read flag per port |
| rd_data | output | 128 | Read data, port A in bits 63:0, port B in bits 127:64 |
| illegal | output | 1 | Illegal floating-point access this cycle |

## Verification
The bench probes the narrow-read boundary from both sides. 0xFFFFFFFF_00000000 must pass through. 0xFFFFFFFE_00000000 and a NaN-looking 64-bit value must become the canonical NaN. A comparison off by one, or a test of only the top bit, would let the wrong values through. It tries writes with the unit off and with the matching width disabled, then reads the target register back. A design that gates only the flag and not the write would show the new data. It issues a state load in the same cycle as a write, where a design with the wrong priority ends dirty. It also reads a register in the cycle it is written, where a missing bypass would return the stale contents.

// File: rtl/fpbox_pkg.sv
// Package: shared state encoding for the NaN-boxing register file.
// Assumes a two-bit state field as seen by the surrounding core.
package fpbox_pkg;

    typedef enum logic [1:0] {
        FS_OFF   = 2'd0,
        FS_INIT  = 2'd1,
        FS_CLEAN = 2'd2,
        FS_DIRTY = 2'd3
    } fs_state_e;

endpackage

// File: rtl/fpbox_access_check.sv
// Module: decides legality of every access in the current cycle.
// Purpose: a write commits only when the unit is on and its width is enabled;
// any enabled read or write that breaks either rule raises the illegal flag.
// Assumes: purely combinational; clk and rst_n serve the assertions only.
module fpbox_access_check #(
    parameter int NRD = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     fs_state,
    input  logic           en_single,
    input  logic           en_double,
    input  logic           wr_en,
    input  logic           wr_narrow,
    input  logic [NRD-1:0] rd_en,
    input  logic [NRD-1:0] rd_narrow,
    output logic           wr_commit,
    output logic           illegal
);
    import fpbox_pkg::*;

    logic           unit_off;
    logic           wr_width_ok;
    logic           wr_bad;
    logic [NRD-1:0] rd_bad;

    // Decode the off state and the write width permission.
    always_comb begin
        unit_off    = (fs_state == FS_OFF);
        wr_width_ok = wr_narrow ? en_single : en_double;
        wr_bad      = wr_en && (unit_off || !wr_width_ok);
        wr_commit   = wr_en && !wr_bad;
    end

    // One legality check per read port.
    for (genvar p = 0; p < NRD; p++) begin : g_rd_chk
        always_comb begin
            rd_bad[p] = rd_en[p] && (unit_off || !(rd_narrow[p] ? en_single : en_double));
        end
    end

    // Merge the per-access faults into one flag.
    always_comb begin
        illegal = wr_bad || (|rd_bad);
    end

    a_r6_off_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_state == FS_OFF) |-> !wr_commit);
    a_r6_off_flags_access: assert property (@(posedge clk) disable iff (!rst_n)
        ((fs_state == FS_OFF) && (wr_en || (|rd_en))) |-> illegal);
    a_r7_width_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> (wr_narrow ? en_single : en_double));

endmodule

// File: rtl/fpbox_status.sv
// Module: holds the floating-point unit state and the summary-dirty bit.
// Purpose: an external load wins; otherwise a committed write marks dirty.
// Assumes: the loaded value is already legal for the core's control logic.
module fpbox_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_commit,
    input  logic       ld,
    input  logic [1:0] ld_val,
    output logic [1:0] fs_state,
    output logic       summary_dirty
);
    import fpbox_pkg::*;

    fs_state_e state_q;
    logic      sd_q;

    // State register: reset to off, load has priority over the dirty update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_OFF;
            sd_q    <= 1'b0;
        end else if (ld) begin
            state_q <= fs_state_e'(ld_val);
            sd_q    <= (ld_val == FS_DIRTY);
        end else if (wr_commit && (state_q != FS_DIRTY)) begin
            state_q <= FS_DIRTY;
            sd_q    <= 1'b1;
        end
    end

    assign fs_state      = state_q;
    assign summary_dirty = sd_q;

    a_r8_write_marks_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit && !ld) |=> (fs_state == FS_DIRTY) && summary_dirty);
    a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (fs_state == $past(ld_val)));
    a_r10_idle_holds_state: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !wr_commit) |=> $stable(fs_state) && $stable(summary_dirty));

endmodule

// File: rtl/fpbox_storage.sv
// Module: the register array with one write port and NRD read ports.
// Purpose: boxes narrow writes on the way in and bypasses a same-cycle write
// to any read port that addresses the written register.
// Assumes: NREGS is a power of two; reads are combinational.
module fpbox_storage #(
    parameter int NREGS  = 32,
    parameter int FLEN   = 64,
    parameter int NARROW = 32,
    parameter int NRD    = 2,
    parameter int AW     = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_commit,
    input  logic [AW-1:0]     wr_addr,
    input  logic              wr_narrow,
    input  logic [FLEN-1:0]   wr_data,
    input  logic [NRD*AW-1:0] rd_addr,
    output logic [NRD*FLEN-1:0] rd_raw
);
    localparam int PAD = FLEN - NARROW;

    logic [FLEN-1:0] regs [NREGS];
    logic [FLEN-1:0] wr_value;

    // Form the stored value: narrow data gets an all-ones upper part.
    always_comb begin
        wr_value = wr_narrow ? {{PAD{1'b1}}, wr_data[NARROW-1:0]} : wr_data;
    end

    // Array update: synchronous clear, then one write per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) begin
                regs[i] <= '0;
            end
        end else if (wr_commit) begin
            regs[wr_addr] <= wr_value;
        end
    end

    a_r2_narrow_stored_boxed: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit && wr_narrow) |=> (&regs[$past(wr_addr)][FLEN-1:NARROW]));

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        logic [AW-1:0] addr_p;
        assign addr_p = rd_addr[p*AW +: AW];

        // Read mux with write-first bypass.
        always_comb begin
            if (wr_commit && (wr_addr == addr_p)) begin
                rd_raw[p*FLEN +: FLEN] = wr_value;
            end else begin
                rd_raw[p*FLEN +: FLEN] = regs[addr_p];
            end
        end

        a_r9_bypass_matches_store: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_commit && (wr_addr == addr_p)) |=>
                (regs[$past(addr_p)] == $past(rd_raw[p*FLEN +: FLEN])));
    end

endmodule

// File: rtl/fpbox_unbox.sv
// Module: narrow-read filter for one read port.
// Purpose: passes a correctly boxed value, replaces anything else with the
// boxed canonical NaN; wide reads pass untouched.
// Assumes: combinational; clk and rst_n serve the assertion only.
module fpbox_unbox #(
    parameter int               FLEN   = 64,
    parameter int               NARROW = 32,
    parameter logic [NARROW-1:0] CANON = 32'h7FC0_0000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            narrow,
    input  logic [FLEN-1:0] raw,
    output logic [FLEN-1:0] val
);
    localparam int PAD = FLEN - NARROW;

    logic boxed_ok;

    // Boxing test: the upper part must be all ones.
    always_comb begin
        boxed_ok = &raw[FLEN-1:NARROW];
        if (!narrow || boxed_ok) begin
            val = raw;
        end else begin
            val = {{PAD{1'b1}}, CANON};
        end
    end

    a_r3_narrow_result_boxed: assert property (@(posedge clk) disable iff (!rst_n)
        narrow |-> (&val[FLEN-1:NARROW]));

endmodule

// File: rtl/fp_boxed_regfile.sv
// Module: top of the NaN-boxing floating-point register file.
// Purpose: ties legality checking, state tracking, storage and per-port
// narrow-read filtering together.
// Assumes: read ports are flattened, port p in slice p of each vector.
module fp_boxed_regfile #(
    parameter int                NREGS  = 32,
    parameter int                FLEN   = 64,
    parameter int                NARROW = 32,
    parameter int                NRD    = 2,
    parameter logic [NARROW-1:0] CANON  = 32'h7FC0_0000,
    parameter int                AW     = $clog2(NREGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_single,
    input  logic                en_double,
    input  logic                fs_load,
    input  logic [1:0]          fs_load_val,
    output logic [1:0]          fs_state,
    output logic                fs_summary_dirty,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic                wr_narrow,
    input  logic [FLEN-1:0]     wr_data,
    input  logic [NRD-1:0]      rd_en,
    input  logic [NRD*AW-1:0]   rd_addr,
    input  logic [NRD-1:0]      rd_narrow,
    output logic [NRD*FLEN-1:0] rd_data,
    output logic                illegal
);
    logic                wr_commit;
    logic [NRD*FLEN-1:0] rd_raw;

    fpbox_access_check #(.NRD(NRD)) u_check (
        .clk       (clk),
        .rst_n     (rst_n),
        .fs_state  (fs_state),
        .en_single (en_single),
        .en_double (en_double),
        .wr_en     (wr_en),
        .wr_narrow (wr_narrow),
        .rd_en     (rd_en),
        .rd_narrow (rd_narrow),
        .wr_commit (wr_commit),
        .illegal   (illegal)
    );

    fpbox_status u_status (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_commit     (wr_commit),
        .ld            (fs_load),
        .ld_val        (fs_load_val),
        .fs_state      (fs_state),
        .summary_dirty (fs_summary_dirty)
    );

    fpbox_storage #(
        .NREGS (NREGS), .FLEN (FLEN), .NARROW (NARROW), .NRD (NRD), .AW (AW)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_commit (wr_commit),
        .wr_addr   (wr_addr),
        .wr_narrow (wr_narrow),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_raw    (rd_raw)
    );

    for (genvar p = 0; p < NRD; p++) begin : g_port
        fpbox_unbox #(.FLEN(FLEN), .NARROW(NARROW), .CANON(CANON)) u_unbox (
            .clk    (clk),
            .rst_n  (rst_n),
            .narrow (rd_narrow[p]),
            .raw    (rd_raw[p*FLEN +: FLEN]),
            .val    (rd_data[p*FLEN +: FLEN])
        );
    end

endmodule

// File: tb/fp_boxed_regfile_tb.sv
module fp_boxed_regfile_tb;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         en_single, en_double;
    logic         fs_load;
    logic [1:0]   fs_load_val;
    logic [1:0]   fs_state;
    logic         fs_summary_dirty;
    logic         wr_en;
    logic [4:0]   wr_addr;
    logic         wr_narrow;
    logic [63:0]  wr_data;
    logic [1:0]   rd_en;
    logic [9:0]   rd_addr;
    logic [1:0]   rd_narrow;
    logic [127:0] rd_data;
    logic         illegal;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [63:0] CNAN = 64'hFFFF_FFFF_7FC0_0000;

    // {write narrow, write data, read narrow, expected}
    localparam logic [129:0] VEC [8] = '{
        {1'b0, 64'h3FF0_0000_0000_0000, 1'b0, 64'h3FF0_0000_0000_0000},
        {1'b1, 64'h1234_5678_3F80_0000, 1'b0, 64'hFFFF_FFFF_3F80_0000},
        {1'b1, 64'hABCD_EF01_4049_0FDB, 1'b1, 64'hFFFF_FFFF_4049_0FDB},
        {1'b0, 64'h0000_0001_3F80_0000, 1'b1, CNAN},
        {1'b0, 64'hFFFF_FFFE_0000_0000, 1'b1, CNAN},
        {1'b0, 64'hFFFF_FFFF_0000_0000, 1'b1, 64'hFFFF_FFFF_0000_0000},
        {1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF},
        {1'b0, 64'h7FF8_0000_0000_0000, 1'b1, CNAN}
    };
    string vtag [8] = '{"R5", "R2", "R3", "R4", "R4", "R3", "R3", "R4"};

    fp_boxed_regfile u_dut (
        .clk (clk), .rst_n (rst_n), .en_single (en_single), .en_double (en_double),
        .fs_load (fs_load), .fs_load_val (fs_load_val), .fs_state (fs_state),
        .fs_summary_dirty (fs_summary_dirty), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_narrow (wr_narrow), .wr_data (wr_data), .rd_en (rd_en),
        .rd_addr (rd_addr), .rd_narrow (rd_narrow), .rd_data (rd_data),
        .illegal (illegal)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load_state(input logic [1:0] v);
        fs_load = 1'b1; fs_load_val = v;
        tick();
        fs_load = 1'b0;
    endtask

    task automatic write(input logic [4:0] a, input logic n, input logic [63:0] d);
        wr_en = 1'b1; wr_addr = a; wr_narrow = n; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic read_a(input logic [4:0] a, input logic n, output logic [63:0] v);
        rd_en[0] = 1'b1; rd_addr[4:0] = a; rd_narrow[0] = n;
        #1;
        v = rd_data[63:0];
        rd_en[0] = 1'b0;
    endtask

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        rst_n = 1'b0; en_single = 1'b1; en_double = 1'b1;
        fs_load = 1'b0; fs_load_val = 2'd0;
        wr_en = 1'b0; wr_addr = '0; wr_narrow = 1'b0; wr_data = '0;
        rd_en = '0; rd_addr = '0; rd_narrow = '0;
        @(negedge clk); tick(); tick();
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 state", 64'(fs_state), 64'd0);
        chk("R1 summary", 64'(fs_summary_dirty), 64'd0);
        for (int r = 0; r < 32; r++) begin
            read_a(5'(r), 1'b0, v);
            chk("R1 reg cleared", v, 64'd0);
        end

        // R6: unit off, write dropped and flagged
        wr_en = 1'b1; wr_addr = 5'd3; wr_narrow = 1'b0; wr_data = 64'hDEAD_BEEF_0BAD_F00D;
        #1 chk("R6 illegal on write", 64'(illegal), 64'd1);
        tick();
        wr_en = 1'b0;
        chk("R6 state stays off", 64'(fs_state), 64'd0);
        rd_en[0] = 1'b1; rd_addr[4:0] = 5'd3;
        #1 chk("R6 illegal on read", 64'(illegal), 64'd1);
        rd_en[0] = 1'b0;
        load_state(2'd2);
        chk("R8 loaded clean", 64'(fs_state), 64'd2);
        chk("R8 summary clear on clean", 64'(fs_summary_dirty), 64'd0);
        read_a(5'd3, 1'b0, v);
        chk("R6 register untouched", v, 64'd0);

        // Vector table: write then read back
        for (int i = 0; i < 8; i++) begin
            write(5'(i + 1), VEC[i][129], VEC[i][128:65]);
            read_a(5'(i + 1), VEC[i][64], v);
            chk(vtag[i], v, VEC[i][63:0]);
        end
        chk("R8 dirty after write", 64'(fs_state), 64'd3);
        chk("R8 summary after write", 64'(fs_summary_dirty), 64'd1);
        read_a(5'd2, 1'b1, v);
        chk("R3 narrow read of boxed narrow write", v, 64'hFFFF_FFFF_3F80_0000);

        // R7: width enables
        en_double = 1'b0;
        wr_en = 1'b1; wr_addr = 5'd20; wr_narrow = 1'b0; wr_data = 64'hA5A5_A5A5_A5A5_A5A5;
        #1 chk("R7 wide write needs double", 64'(illegal), 64'd1);
        tick();
        wr_en = 1'b0; en_double = 1'b1;
        read_a(5'd20, 1'b0, v);
        chk("R7 dropped wide write", v, 64'd0);
        en_double = 1'b0;
        wr_en = 1'b1; wr_addr = 5'd21; wr_narrow = 1'b1; wr_data = 64'h1111_1111_2222_3333;
        #1 chk("R7 narrow write legal without double", 64'(illegal), 64'd0);
        tick();
        wr_en = 1'b0; en_double = 1'b1;
        read_a(5'd21, 1'b0, v);
        chk("R7 narrow write stored", v, 64'hFFFF_FFFF_2222_3333);
        en_single = 1'b0;
        rd_en[0] = 1'b1; rd_addr[4:0] = 5'd21; rd_narrow[0] = 1'b1;
        #1 chk("R7 narrow read needs single", 64'(illegal), 64'd1);
        rd_narrow[0] = 1'b0;
        #1 chk("R7 wide read legal", 64'(illegal), 64'd0);
        rd_en[0] = 1'b0; en_single = 1'b1;

        // R8: dirty tracking and load priority
        load_state(2'd2);
        write(5'd22, 1'b0, 64'h0123_4567_89AB_CDEF);
        chk("R8 clean to dirty", 64'(fs_state), 64'd3);
        chk("R8 summary set", 64'(fs_summary_dirty), 64'd1);
        fs_load = 1'b1; fs_load_val = 2'd1;
        write(5'd23, 1'b0, 64'h5555_6666_7777_8888);
        fs_load = 1'b0;
        chk("R8 load wins over write", 64'(fs_state), 64'd1);
        chk("R8 summary follows load", 64'(fs_summary_dirty), 64'd0);
        read_a(5'd23, 1'b0, v);
        chk("R8 write still committed", v, 64'h5555_6666_7777_8888);
        load_state(2'd3);
        chk("R8 summary on dirty load", 64'(fs_summary_dirty), 64'd1);

        // R10: reads leave the state alone
        load_state(2'd2);
        rd_en = 2'b11; rd_addr = {5'd22, 5'd1}; rd_narrow = 2'b01;
        tick(); tick(); tick();
        rd_en = 2'b00;
        chk("R10 state after reads", 64'(fs_state), 64'd2);
        chk("R10 summary after reads", 64'(fs_summary_dirty), 64'd0);

        // R9: same-cycle bypass
        wr_en = 1'b1; wr_addr = 5'd24; wr_narrow = 1'b1; wr_data = 64'h9999_0000_3F00_0000;
        rd_en = 2'b11; rd_addr = {5'd24, 5'd24}; rd_narrow = 2'b01;
        #1;
        chk("R9 bypass wide port", rd_data[127:64], 64'hFFFF_FFFF_3F00_0000);
        chk("R9 bypass narrow port", rd_data[63:0], 64'hFFFF_FFFF_3F00_0000);
        tick();
        wr_narrow = 1'b0; wr_data = 64'h0000_0001_4000_0000;
        #1;
        chk("R9 bypass then filter", rd_data[63:0], CNAN);
        chk("R9 bypass wide value", rd_data[127:64], 64'h0000_0001_4000_0000);
        tick();
        wr_en = 1'b0; rd_en = 2'b00; rd_narrow = 2'b00;

        // R1: reset clears written registers
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        chk("R1 state after reset", 64'(fs_state), 64'd0);
        read_a(5'd1, 1'b0, v);
        chk("R1 reg1 cleared", v, 64'd0);
        read_a(5'd24, 1'b0, v);
        chk("R1 reg24 cleared", v, 64'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule